// File: doc/BRIEF.md
# B3ZS Line Encoder and Decoder

This block sits between a serial NRZ data path and the dual-rail line side of a DS3-rate interface, with everything in one bit-rate clock domain. In the transmit direction it turns a single-rail bit stream into positive and negative pulse rails. Ones are sent as pulses that alternate in polarity. Every run of three zeros is swapped for a substitution code that contains a deliberate polarity violation, so the line never goes quiet for long.

In the receive direction it reads the two rails back. It recognises legal substitutions and restores them to zeros. Any line event that a correct encoder could never have produced raises a one-cycle coding-violation flag. A loopback control feeds the encoder's rails straight into the decoder in place of the receive pins, so the whole data path can be tested without a line.

Substitutions are chosen so that successive violation pulses are always separated by an odd number of ordinary pulses. This keeps the line free of DC content, and it lets the receiver tell a substitution apart from line damage.

Top module: `b3zs_codec`

## Requirements
- R1: A one on `tx_nrz` is sent as a single pulse whose polarity is opposite to the previously sent pulse (the first pulse after reset is positive). A zero that is not part of a substitution sends no pulse. A bit sampled on clock edge k appears on `line_tx_pos`/`line_tx_neg` after edge k+2.
- R2: Each run of three input zeros is replaced by one of two codes, written oldest first: "B 0 V" or "0 0 V". B has the polarity opposite to the pulse sent before it. V has the same polarity as the pulse sent before it.
- R3: The encoder sends "0 0 V" when the number of conforming pulses (ones and B pulses) sent since the last V, or since reset, is odd. It sends "B 0 V" when that number is even. As a result, the count between any two V pulses is odd.
- R4: While `rst_n` is low at a clock edge, all outputs go low after that edge. Encoder and decoder history is cleared.
- R5: In the decoder, a pulse on exactly one rail decodes as 1 and an empty slot decodes as 0. A symbol sampled on edge k is decoded onto `rx_nrz` after edge k+2. A violation (a pulse with the same polarity as the previous pulse) is legal when the slot just before it is empty and the slot before that is either empty or a non-violating pulse. A legal violation decodes as 0 in all three positions.
- R6: A violation that is not legal raises `rx_cv` for the one cycle after the edge on which it is sampled, and it decodes as 1.
- R7: Each time a symbol and the two symbols before it are all empty, `rx_cv` is raised for the one cycle after that symbol's edge.
- R8: A slot with both rails high raises `rx_cv` and decodes as 0. It does not change the remembered polarity, and it is neither empty nor a pulse for the checks in R5 and R7. The R6 and R7 checks are armed by the first single-rail pulse after reset; before that, no pulse is a violation and empty runs are not flagged.
- R9: With `loop_en` high, the decoder takes the encoder's rails and ignores `line_rx_pos`/`line_rx_neg`. A bit sampled from `tx_nrz` on edge k then appears on `rx_nrz` after edge k+5, and `rx_cv` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_nrz | input | 1 | Transmit NRZ data |
| loop_en | input | 1 | Route encoder rails into the decoder |
| line_rx_pos | input | 1 | Received positive-pulse rail |
| line_rx_neg | input | 1 | Received negative-pulse rail |
| line_tx_pos | output | 1 | Transmitted positive-pulse rail |
| line_tx_neg | output | 1 | Transmitted negative-pulse rail |
| rx_nrz | output | 1 | Decoded NRZ data |
| rx_cv | output | 1 | Coding-violation flag, one cycle per event |

## Verification
The bench loops back every 8-bit pattern, concatenated into one stream and followed by long runs of zeros and ones. Each rail is compared with an arithmetic model of the substitution choice. This catches an encoder that gets the parity wrong after back-to-back substitutions, or that flips the polarity of B or V: the rails would diverge, and the decoder would flag a violation. A scripted receive sequence covers the following cases:
- an unarmed line, where a premature check would flag idle zeros;
- a violation directly after a pulse;
- a violation after a both-rails slot;
- a violation in V0V spacing, which a decoder that only looks at the last slot would accept as legal;
- empty runs of three and four slots;
- both-rails slots that must not disturb the remembered polarity.

Misaligned clearing of a legal substitution would show up as stray ones on `rx_nrz`.

// File: rtl/b3zs_pkg.sv
`timescale 1ns/1ps
// Shared symbol types for the B3ZS encoder and decoder.
package b3zs_pkg;

    // Encoder pipeline slot contents.
    typedef enum logic [1:0] {
        ES_ZERO = 2'd0,   // no pulse
        ES_BIP  = 2'd1,   // conforming pulse (data one or B)
        ES_VIOL = 2'd2    // violation pulse of a substitution
    } enc_sym_e;

    // Decoder history slot classification.
    typedef enum logic [1:0] {
        DK_ZERO = 2'd0,   // empty slot
        DK_MARK = 2'd1,   // conforming pulse
        DK_VIOL = 2'd2,   // violation pulse
        DK_BOTH = 2'd3    // both rails high
    } dec_kind_e;

    // Round-trip latency through encoder and decoder in loopback.
    localparam int unsigned LOOP_LATENCY = 5;

endpackage

// File: rtl/b3zs_enc.sv
`timescale 1ns/1ps
// B3ZS encoder.
// Purpose: turns NRZ bits into alternating-polarity pulses, replacing each
// run of three zeros with B0V or 00V chosen from the parity of conforming
// pulses since the last V.
// Assumes: one bit per clock; two slots of look-ahead, so output lags input
// by three registers (input edge k, rails valid after edge k+2).
module b3zs_enc
    import b3zs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_in,
    output logic pos_o,
    output logic neg_o
);

    enc_sym_e   slot0_q;     // newest pending symbol
    enc_sym_e   slot1_q;     // oldest pending symbol, emitted next
    logic [1:0] zrun_q;      // unsubstituted zeros held in the pipeline
    logic       last_pos_q;  // polarity of last sent pulse (1 = positive)
    logic       odd_q;       // odd number of conforming pulses since last V
    logic       subst;
    enc_sym_e   emit;
    logic       emit_pulse;
    logic       emit_pos;

    // Third zero in a row: the two held zeros plus this one form a group.
    always_comb subst = !nrz_in && (zrun_q == 2'd2);

    // Pick the symbol that leaves the pipeline this cycle.
    always_comb begin
        emit = slot1_q;
        if (subst) emit = odd_q ? ES_ZERO : ES_BIP;
    end

    // Polarity: V repeats the previous pulse, everything else alternates.
    always_comb begin
        emit_pulse = (emit != ES_ZERO);
        emit_pos   = (emit == ES_VIOL) ? last_pos_q : !last_pos_q;
    end

    // Pipeline advance, zero-run count and rail registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot0_q    <= ES_ZERO;
            slot1_q    <= ES_ZERO;
            zrun_q     <= 2'd0;
            last_pos_q <= 1'b0;
            odd_q      <= 1'b0;
            pos_o      <= 1'b0;
            neg_o      <= 1'b0;
        end else begin
            slot1_q <= slot0_q;
            if (subst)       slot0_q <= ES_VIOL;
            else if (nrz_in) slot0_q <= ES_BIP;
            else             slot0_q <= ES_ZERO;

            if (nrz_in || subst) zrun_q <= 2'd0;
            else                 zrun_q <= zrun_q + 2'd1;

            pos_o <= emit_pulse && emit_pos;
            neg_o <= emit_pulse && !emit_pos;
            if (emit_pulse) last_pos_q <= emit_pos;

            if (emit == ES_VIOL)     odd_q <= 1'b0;
            else if (emit == ES_BIP) odd_q <= !odd_q;
        end
    end

    // R3: every V leaves with an odd count of conforming pulses behind it.
    p_odd_between_viol_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (emit == ES_VIOL) |-> odd_q);

endmodule

// File: rtl/b3zs_dec.sv
`timescale 1ns/1ps
// B3ZS decoder.
// Purpose: classifies each rail pair, clears legal substitutions to zeros
// and flags illegal violations, empty triples and both-rails slots.
// Assumes: one symbol per clock; decoded data lags by three registers
// (symbol edge k, data valid after edge k+2); coding-violation flag is
// registered on the edge that samples the offending symbol.
module b3zs_dec
    import b3zs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rail_pos,
    input  logic rail_neg,
    output logic data_o,
    output logic cv_o
);

    dec_kind_e kind0_q, kind1_q;  // classes of the previous two slots
    logic      dat0_q, dat1_q;    // pending decoded bits
    logic      last_pos_q;        // polarity of last single-rail pulse
    logic      armed_q;           // a pulse has been seen since reset
    logic      both, pulse, is_v, legal_v, bad_v, zero_triple;

    // Classify the incoming slot against the history.
    always_comb begin
        both        = rail_pos && rail_neg;
        pulse       = rail_pos ^ rail_neg;
        is_v        = pulse && armed_q && (rail_pos == last_pos_q);
        legal_v     = is_v && (kind0_q == DK_ZERO)
                      && ((kind1_q == DK_ZERO) || (kind1_q == DK_MARK));
        bad_v       = is_v && !legal_v;
        zero_triple = !rail_pos && !rail_neg && armed_q
                      && (kind0_q == DK_ZERO) && (kind1_q == DK_ZERO);
    end

    // History shift, substitution clearing and flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind0_q    <= DK_ZERO;
            kind1_q    <= DK_ZERO;
            dat0_q     <= 1'b0;
            dat1_q     <= 1'b0;
            last_pos_q <= 1'b0;
            armed_q    <= 1'b0;
            data_o     <= 1'b0;
            cv_o       <= 1'b0;
        end else begin
            kind1_q <= kind0_q;
            if (both)       kind0_q <= DK_BOTH;
            else if (!pulse) kind0_q <= DK_ZERO;
            else if (is_v)  kind0_q <= DK_VIOL;
            else            kind0_q <= DK_MARK;

            dat0_q <= pulse && !legal_v;
            dat1_q <= legal_v ? 1'b0 : dat0_q;
            data_o <= legal_v ? 1'b0 : dat1_q;
            cv_o   <= both || bad_v || zero_triple;

            if (pulse) begin
                last_pos_q <= rail_pos;
                armed_q    <= 1'b1;
            end
        end
    end

    // R5: the oldest slot of a legal substitution leaves as zero.
    p_bslot_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        legal_v |=> !data_o);

    // R5: the V slot itself leaves as zero two cycles later.
    p_vslot_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        legal_v |=> ##2 !data_o);

    // R8: once armed, the decoder stays armed until reset.
    p_arm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> armed_q);

endmodule

// File: rtl/b3zs_codec.sv
`timescale 1ns/1ps
// B3ZS codec top.
// Purpose: pairs the encoder and decoder and selects the decoder source
// between the receive rails and a local loopback of the encoder rails.
// Assumes: a single bit-rate clock for both directions.
module b3zs_codec
    import b3zs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_nrz,
    input  logic loop_en,
    input  logic line_rx_pos,
    input  logic line_rx_neg,
    output logic line_tx_pos,
    output logic line_tx_neg,
    output logic rx_nrz,
    output logic rx_cv
);

    logic dec_pos, dec_neg;

    b3zs_enc u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .nrz_in (tx_nrz),
        .pos_o  (line_tx_pos),
        .neg_o  (line_tx_neg)
    );

    // Decoder source: encoder rails in loopback, receive pins otherwise.
    always_comb begin
        dec_pos = loop_en ? line_tx_pos : line_rx_pos;
        dec_neg = loop_en ? line_tx_neg : line_rx_neg;
    end

    b3zs_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rail_pos (dec_pos),
        .rail_neg (dec_neg),
        .data_o   (rx_nrz),
        .cv_o     (rx_cv)
    );

endmodule

// File: tb/b3zs_codec_tb.sv
`timescale 1ns/1ps
module b3zs_codec_tb;

    localparam int NB = 256 * 8 + 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_nrz = 1'b0;
    logic loop_en = 1'b0;
    logic line_rx_pos = 1'b0;
    logic line_rx_neg = 1'b0;
    logic line_tx_pos, line_tx_neg, rx_nrz, rx_cv;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic bs [0:NB-1];
    logic ep [0:NB-1];
    logic en [0:NB-1];
    int   kd [0:NB-1];

    always #4 clk = ~clk;

    b3zs_codec u_dut (
        .clk(clk), .rst_n(rst_n), .tx_nrz(tx_nrz), .loop_en(loop_en),
        .line_rx_pos(line_rx_pos), .line_rx_neg(line_rx_neg),
        .line_tx_pos(line_tx_pos), .line_tx_neg(line_tx_neg),
        .rx_nrz(rx_nrz), .rx_cv(rx_cv)
    );

    task automatic chk(input string req, input int idx, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0d: got %0b expected %0b", req, idx, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Reference encoding from R1-style rules: group marking, then polarity.
    task automatic build_model();
        int z = 0;
        logic last = 1'b0;
        logic odd = 1'b0;
        for (int p = 0; p < 256; p++)
            for (int b = 7; b >= 0; b--) bs[p*8 + (7-b)] = p[b];
        for (int i = 0; i < 12; i++) bs[2048 + i] = 1'b0;
        for (int i = 0; i < 12; i++) bs[2060 + i] = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (bs[i]) begin kd[i] = 1; z = 0; end
            else if (z == 2) begin kd[i] = 2; kd[i-1] = 0; kd[i-2] = 3; z = 0; end
            else begin kd[i] = 0; z++; end
        end
        for (int j = 0; j < NB; j++) begin
            int k = kd[j];
            logic pol;
            if (k == 3) k = odd ? 0 : 1;
            ep[j] = 1'b0; en[j] = 1'b0;
            if (k == 1) begin
                pol = !last; last = pol; odd = !odd;
                ep[j] = pol; en[j] = !pol;
            end else if (k == 2) begin
                pol = last; odd = 1'b0;
                ep[j] = pol; en[j] = !pol;
            end
        end
    endtask

    initial begin : main
        string sy, sd, sc;
        build_model();

        // Phase 1: loopback sweep; receive pins held both-high (ignored, R9).
        loop_en = 1'b1; line_rx_pos = 1'b1; line_rx_neg = 1'b1;
        do_reset();
        for (int c = 0; c < NB + 7; c++) begin
            if (c > 0) @(negedge clk);
            if (c == 0) begin
                chk("R4 reset pos", c, line_tx_pos, 1'b0);
                chk("R4 reset neg", c, line_tx_neg, 1'b0);
                chk("R4 reset data", c, rx_nrz, 1'b0);
                chk("R4 reset cv", c, rx_cv, 1'b0);
            end
            if (c >= 3 && c - 3 < NB) begin
                chk("R1,R2,R3 pos rail", c - 3, line_tx_pos, ep[c-3]);
                chk("R1,R2,R3 neg rail", c - 3, line_tx_neg, en[c-3]);
            end
            if (c >= 6 && c - 6 < NB) chk("R9 loop data", c - 6, rx_nrz, bs[c-6]);
            if (c >= 1) chk("R9 loop cv", c, rx_cv, 1'b0);
            tx_nrz = (c < NB) ? bs[c] : 1'b1;
        end

        // Phase 2: scripted receive symbols (0 empty, + pos, - neg, X both).
        sy = "0000-+00+--+-0-0000+X+-0-0-+-+";
        sd = "000011000111000000010100001111";
        sc = "000000000010000001101100001000";
        loop_en = 1'b0; line_rx_pos = 1'b0; line_rx_neg = 1'b0;
        do_reset();
        for (int c = 0; c < sy.len() + 3; c++) begin
            if (c > 0) @(negedge clk);
            if (c == 0) begin
                chk("R4 reset data", c, rx_nrz, 1'b0);
                chk("R4 reset cv", c, rx_cv, 1'b0);
            end
            if (c >= 1 && c - 1 < sy.len())
                chk("R6,R7,R8 cv", c - 1, rx_cv, sc[c-1] == "1");
            if (c >= 3 && c - 3 < sy.len())
                chk("R5,R6,R8 data", c - 3, rx_nrz, sd[c-3] == "1");
            if (c < sy.len()) begin
                line_rx_pos = (sy[c] == "+") || (sy[c] == "X");
                line_rx_neg = (sy[c] == "-") || (sy[c] == "X");
            end else begin
                line_rx_pos = 1'b0; line_rx_neg = 1'b0;
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule